// File: doc/BRIEF.md
# Range Detect and Output Code Formatter

This block sits at the end of a measurement data path. It takes a 24-bit signed sample whose offset has already been removed, together with the channel's positive and negative gain limits. It decides whether the sample lies above the positive limit, below the lower limit, or inside the span. It then produces a 16-bit result word in the numeric code that the mode bits select. In-range samples are truncated to 16 bits. Out-of-range samples are clamped to the extreme code of the selected format.

Two mode inputs select the behaviour. The bipolar/unipolar bit decides how the lower limit is tested and which bits of the sample form the result. The two's complement select bit chooses between two's complement and offset binary, and it only has an effect in bipolar mode. A strobed sample is classified and coded in one pass, and it appears at the outputs one clock later.

The registered range class holds one of three named states. `RNG_IN` means the sample is inside the span, `RNG_OVER` means it is above the positive limit, and `RNG_UNDER` means it is below the lower limit. The class moves to the state chosen by the detector on every strobed cycle and keeps its state on every other cycle. The code format is one of three named selections: `CODE_UNI`, `CODE_OFFBIN` and `CODE_TWOS`.

Top module: `range_code_formatter`

## Requirements
- R1: Over range is flagged when the signed sample is strictly greater than the signed positive limit, in both modes. A sample equal to the limit is in range.
- R2: In unipolar mode, under range is flagged exactly when the sample's sign bit (bit 23) is 1. The negative limit has no effect in this mode.
- R3: In bipolar mode, under range is flagged when the signed sample is strictly less than the signed negative limit. A sample equal to the limit is in range.
- R4: When a sample satisfies both the over test and the under test, only over range is reported. The two flags are never high together.
- R5: In bipolar mode with the select bit at 1, an in-range sample is output as sample bits [23:8], in two's complement.
- R6: In bipolar mode with the select bit at 0, an in-range sample is output as sample bits [23:8] with bit 15 inverted (offset binary). Half scale is therefore 0x8000.
- R7: In unipolar mode, an in-range sample is output as straight binary taken from sample bits [22:7]. The select bit is ignored.
- R8: On over range the output clamps to 0x7FFF in two's complement, and to 0xFFFF in offset binary and in unipolar binary.
- R9: On under range the output clamps to 0x8000 in two's complement, and to 0x0000 in offset binary and in unipolar binary.
- R10: The code word and the flags for a strobed sample appear one clock after the strobe, with output valid high for that one cycle. After a cycle without a strobe, output valid is low and the code word and flags keep their values.
- R11: While reset is asserted, output valid is low, the code word is 0x0000 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking a new sample |
| in_value | input | 24 | Offset-corrected signed sample |
| pos_coef | input | 24 | Signed positive gain limit |
| neg_coef | input | 24 | Signed negative gain limit (bipolar only) |
| bipolar | input | 1 | 1 = bipolar mode, 0 = unipolar mode |
| twos_sel | input | 1 | 1 = two's complement, 0 = offset binary (bipolar only) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_code | output | 16 | Coded result word |
| over_flag | output | 1 | Sample was above the positive limit |
| under_flag | output | 1 | Sample was below the lower limit |

## Verification
The bench places samples exactly on each limit and one LSB beyond it. A design that used a non-strict comparison would clamp the boundary samples that belong in range. It applies a negative sample in unipolar mode with the select bit set, which catches a design that clamps to 0x8000 or honours the select bit there. A sample that is both above the positive limit and below the negative limit catches a design that reports both flags or lets under range win. An unstrobed cycle and a mid-run reset check that stale results hold and that reset clears everything.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    typedef enum logic [1:0] {
        RNG_IN    = 2'd0,
        RNG_OVER  = 2'd1,
        RNG_UNDER = 2'd2
    } range_t;

    typedef enum logic [1:0] {
        CODE_UNI    = 2'd0,
        CODE_OFFBIN = 2'd1,
        CODE_TWOS   = 2'd2
    } code_t;

endpackage

// File: rtl/rcf_range_detect.sv
module rcf_range_detect
    import rcf_pkg::*;
#(
    parameter int VAL_W = 24
) (
    input  logic [VAL_W-1:0] value,
    input  logic [VAL_W-1:0] pos_lim,
    input  logic [VAL_W-1:0] neg_lim,
    input  logic             bipolar,
    output range_t           rng
);
    localparam int SIGN = VAL_W - 1;

    logic above_pos;
    logic below_low;

    // Strictly above the positive limit: same test in either mode.
    assign above_pos = $signed(value) > $signed(pos_lim);

    // Lower test: a sign check when unipolar, a limit compare when bipolar.
    generate
        if (VAL_W > 1) begin : g_low
            assign below_low = bipolar ? ($signed(value) < $signed(neg_lim))
                                       : value[SIGN];
        end
    endgenerate

    // Over range takes priority when both tests fire.
    always_comb begin
        if (above_pos)      rng = RNG_OVER;
        else if (below_low) rng = RNG_UNDER;
        else                rng = RNG_IN;
    end
endmodule

// File: rtl/rcf_code_map.sv
module rcf_code_map
    import rcf_pkg::*;
#(
    parameter int VAL_W = 24,
    parameter int OUT_W = 16
) (
    input  logic [VAL_W-1:0] value,
    input  range_t           rng,
    input  code_t            fmt,
    output logic [OUT_W-1:0] word
);
    localparam int MSB = VAL_W - 1;
    localparam logic [OUT_W-1:0] ALL_ONES = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] ALL_ZERO = {OUT_W{1'b0}};
    localparam logic [OUT_W-1:0] POS_MAX  = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN  = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] bip_slice;
    logic [OUT_W-1:0] uni_slice;

    assign bip_slice = value[MSB -: OUT_W];
    assign uni_slice = value[MSB-1 -: OUT_W];

    always_comb begin
        word = ALL_ZERO;
        unique case (rng)
            RNG_OVER:  word = (fmt == CODE_TWOS) ? POS_MAX : ALL_ONES;
            RNG_UNDER: word = (fmt == CODE_TWOS) ? NEG_MIN : ALL_ZERO;
            RNG_IN: begin
                unique case (fmt)
                    CODE_TWOS:   word = bip_slice;
                    CODE_OFFBIN: word = {~bip_slice[OUT_W-1], bip_slice[OUT_W-2:0]};
                    CODE_UNI:    word = uni_slice;
                    default:     word = ALL_ZERO;
                endcase
            end
            default:   word = ALL_ZERO;
        endcase
    end
endmodule

// File: rtl/range_code_formatter.sv
module range_code_formatter
    import rcf_pkg::*;
#(
    parameter int VAL_W = 24,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_value,
    input  logic [VAL_W-1:0] pos_coef,
    input  logic [VAL_W-1:0] neg_coef,
    input  logic             bipolar,
    input  logic             twos_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code,
    output logic             over_flag,
    output logic             under_flag
);
    range_t           rng_d;
    range_t           rng_q;
    code_t            fmt;
    logic [OUT_W-1:0] word_d;

    // Unipolar ignores the select bit entirely.
    assign fmt = !bipolar ? CODE_UNI : (twos_sel ? CODE_TWOS : CODE_OFFBIN);

    rcf_range_detect #(.VAL_W(VAL_W)) u_detect (
        .value   (in_value),
        .pos_lim (pos_coef),
        .neg_lim (neg_coef),
        .bipolar (bipolar),
        .rng     (rng_d)
    );

    rcf_code_map #(.VAL_W(VAL_W), .OUT_W(OUT_W)) u_map (
        .value (in_value),
        .rng   (rng_d),
        .fmt   (fmt),
        .word  (word_d)
    );

    // Range-class state register: takes the detector's choice on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rng_q     <= RNG_IN;
            out_code  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                rng_q    <= rng_d;
                out_code <= word_d;
            end
        end
    end

    // Flags decoded from the registered range class.
    always_comb begin
        over_flag  = 1'b0;
        under_flag = 1'b0;
        unique case (rng_q)
            RNG_OVER:  over_flag  = 1'b1;
            RNG_UNDER: under_flag = 1'b1;
            RNG_IN:    ;
            default:   ;
        endcase
    end

    assert_over_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ($signed(in_value) > $signed(pos_coef))) |=> (out_valid && over_flag));

    assert_uni_sign_under_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bipolar && in_value[VAL_W-1] && !($signed(in_value) > $signed(pos_coef)))
        |=> under_flag);

    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_flag && under_flag));

    assert_twos_over_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bipolar && twos_sel && ($signed(in_value) > $signed(pos_coef)))
        |=> (out_code == {1'b0, {(OUT_W-1){1'b1}}}));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_code)));
endmodule

// File: tb/tb_range_code_formatter.sv
`timescale 1ns/1ps
module tb_range_code_formatter;
    localparam int VW = 24;
    localparam int OW = 16;
    localparam int VEC_W = 2 + 3*VW + OW + 2;
    localparam int NV = 18;

    // {bipolar, twos_sel, value, pos, neg, expected code, exp over, exp under}
    localparam logic [VEC_W-1:0] VEC [NV] = '{
        {1'b1,1'b1,24'h123456,24'h7F0000,24'h810000,16'h1234,1'b0,1'b0}, // R5
        {1'b1,1'b0,24'h123456,24'h7F0000,24'h810000,16'h9234,1'b0,1'b0}, // R6
        {1'b1,1'b1,24'hFFF000,24'h7F0000,24'h810000,16'hFFF0,1'b0,1'b0}, // R5 negative
        {1'b1,1'b0,24'hFFF000,24'h7F0000,24'h810000,16'h7FF0,1'b0,1'b0}, // R6 negative
        {1'b1,1'b1,24'h7F0001,24'h7F0000,24'h810000,16'h7FFF,1'b1,1'b0}, // R1 R8
        {1'b1,1'b0,24'h7F0000,24'h7F0000,24'h810000,16'hFF00,1'b0,1'b0}, // R1 equal
        {1'b1,1'b0,24'h7F0001,24'h7F0000,24'h810000,16'hFFFF,1'b1,1'b0}, // R8 offbin
        {1'b1,1'b1,24'h80FFFF,24'h7F0000,24'h810000,16'h8000,1'b0,1'b1}, // R3 R9
        {1'b1,1'b0,24'h810000,24'h7F0000,24'h810000,16'h0100,1'b0,1'b0}, // R3 equal
        {1'b1,1'b0,24'h80FFFF,24'h7F0000,24'h810000,16'h0000,1'b0,1'b1}, // R9 offbin
        {1'b0,1'b1,24'h123456,24'h7F0000,24'h810000,16'h2468,1'b0,1'b0}, // R7 sel=1
        {1'b0,1'b0,24'h123456,24'h7F0000,24'h810000,16'h2468,1'b0,1'b0}, // R7 sel=0
        {1'b0,1'b1,24'hFFFFFF,24'h7F0000,24'h810000,16'h0000,1'b0,1'b1}, // R2 R9
        {1'b0,1'b0,24'h7F0001,24'h7F0000,24'h810000,16'hFFFF,1'b1,1'b0}, // R1 unipolar
        {1'b0,1'b0,24'h7F0000,24'h7F0000,24'h810000,16'hFE00,1'b0,1'b0}, // R1 uni equal
        {1'b1,1'b1,24'h000050,24'h000010,24'h000100,16'h7FFF,1'b1,1'b0}, // R4
        {1'b0,1'b1,24'h004000,24'h7F0000,24'h7FFFFF,16'h0080,1'b0,1'b0}, // R2 neg ignored
        {1'b1,1'b0,24'h000000,24'h7F0000,24'h810000,16'h8000,1'b0,1'b0}  // R6 half scale
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_value = '0;
    logic [VW-1:0] pos_coef = '0;
    logic [VW-1:0] neg_coef = '0;
    logic          bipolar = 1'b0;
    logic          twos_sel = 1'b0;
    logic          out_valid;
    logic [OW-1:0] out_code;
    logic          over_flag;
    logic          under_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    range_code_formatter #(.VAL_W(VW), .OUT_W(OW)) dut (
        .clk, .rst_n, .in_valid, .in_value, .pos_coef, .neg_coef,
        .bipolar, .twos_sel, .out_valid, .out_code, .over_flag, .under_flag
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [OW-1:0] code,
                             input logic ov, input logic un, input logic vld);
        check({req, " code"}, 32'(out_code), 32'(code));
        check({req, " over"}, 32'(over_flag), 32'(ov));
        check({req, " under"}, 32'(under_flag), 32'(un));
        check({req, " valid"}, 32'(out_valid), 32'(vld));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R11 reset", 16'h0000, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {bipolar, twos_sel, in_value, pos_coef, neg_coef} = VEC[i][VEC_W-1 -: 2+3*VW];
            in_valid = 1'b1;
            @(negedge clk);
            check_all($sformatf("R10 vec%0d", i), VEC[i][OW+1:2], VEC[i][1], VEC[i][0], 1'b1);
        end
        // R10: an unstrobed cycle with new inputs changes nothing
        in_valid = 1'b0;
        bipolar  = 1'b1; twos_sel = 1'b1;
        in_value = 24'h7FFFFF; pos_coef = 24'h000000;
        @(negedge clk);
        check_all("R10 idle hold", 16'h8000, 1'b0, 1'b0, 1'b0);
        // R8 then R11: a mid-run reset clears the over result
        in_valid = 1'b1;
        @(negedge clk);
        check_all("R8 pre-reset", 16'h7FFF, 1'b1, 1'b0, 1'b1);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_all("R11 mid reset", 16'h0000, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 2000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule